// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives serial audio on four data pins. An external bit clock and an external frame clock time the data. The block never drives either clock. All three serial inputs are oversampled in the block's own system clock domain. The block turns each received word into a 24-bit two's-complement sample, widens it by sign extension to a 28-bit core word, and presents it on one output lane per data pin. Each lane carries a one-cycle valid strobe, a 4-bit channel number and the 28-bit word.

A 3-bit format code selects one of eight framings:

- three two-channel justifications, with the right-justified one offered at four word widths;
- a time-division mode of 8 channels on each of two wires;
- a time-division mode of 16 channels on one wire.

Samples are handed out as soon as they are complete. Nothing is held from one frame to the next.

Top module: `sai_rx_top`

## Requirements
- R1: Bit clock and frame clock are inputs only. A data or frame bit is taken only at a rising edge of the bit clock, so data changes while the bit clock stays high do not alter any output sample. Every valid strobe follows such an edge.
- R2: The format code `fmt_sel` selects the framing as follows: 0 = I2S, 1 = left-justified, 2/3/4/5 = right-justified with 24/20/18/16-bit words, 6 = two-wire 8-channel TDM, 7 = one-wire 16-channel TDM.
- R3: In I2S mode (code 0), the MSB of each word is the second bit after a frame-clock transition, and 24 bits are taken MSB first.
- R4: In left-justified mode (code 1), the MSB of each word is the first bit after a frame-clock transition, and 24 bits are taken MSB first.
- R5: In right-justified modes (codes 2..5), the LSB is the last bit before the next frame-clock transition. The word has W bits (24/20/18/16). The sample is those W bits placed at the top of the 24-bit field with zeros below. It is emitted when that transition arrives.
- R6: In the two-channel modes, pin k delivers channel 2k for words sent while the frame clock is low and channel 2k+1 for words sent while it is high.
- R7: In code 6, slot s on pin 3 is channel s and slot s on pin 2 is channel 8+s, for s = 0..7. Later slots are dropped.
- R8: In code 7, slot s on pin 2 is channel s for s = 0..15. In either TDM mode, pins that carry no TDM stream give no valid strobe.
- R9: In TDM modes, the bit taken at a rising frame-clock edge is bit 0 of slot 0. Slots are 32 bit clocks wide, and the first 24 bits of each slot are the sample, MSB first.
- R10: The 28-bit output word is the 24-bit sample with its sign bit copied into the top 4 bits.
- R11: After reset, all valid strobes are low. No sample is produced before the first frame-clock transition that the block sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used for oversampling the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | External serial bit clock |
| frame_clk | input | 1 | External left/right or frame-sync clock |
| sdin | input | 4 | Serial data pins, bit k is pin k |
| fmt_sel | input | 3 | Framing code (see R2) |
| smp_valid | output | 4 | One-cycle strobe per lane, bit k for pin k |
| smp_chan | output | 16 | Channel number, 4 bits per lane, lane k at [4k+3:4k] |
| smp_data | output | 112 | Sign-extended sample, 28 bits per lane, lane k at [28k+27:28k] |

## Verification
The assertions assume the following about the inputs:

- The bit clock stays high and low for at least two system clocks each.
- Data and frame clock are steady around each rising bit-clock edge.
- `fmt_sel` changes only while reset is held.

Under these assumptions a strobe can only follow a sampled edge, and the channel and lane relations hold. The stimulus meets them by design. Each bit clock lasts eight system clocks, and data and frame clock change only while the bit clock is low, except in the one deliberate case of disturbed data during the high phase. Each format is entered under reset.

// File: rtl/sai_rx_pkg.sv
// Package: shared widths, framing codes and helpers for the serial audio receiver.
// Assumes: 24-bit samples, 28-bit core words, 32-clock TDM slots.
package sai_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CORE_W   = 28;
    localparam int LANES    = 4;
    localparam int SLOT_W   = 32;
    localparam int TDM_CH   = 16;
    localparam int CH_W     = $clog2(TDM_CH);
    localparam int POS_W    = $clog2(TDM_CH * SLOT_W);

    // Pin roles in TDM: the low bank pin, the high bank / single-wire pin.
    localparam int PIN_TDM_LO = 3;
    localparam int PIN_TDM_HI = 2;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_LJ    = 3'd1,
        FMT_RJ24  = 3'd2,
        FMT_RJ20  = 3'd3,
        FMT_RJ18  = 3'd4,
        FMT_RJ16  = 3'd5,
        FMT_TDM8  = 3'd6,
        FMT_TDM16 = 3'd7
    } fmt_e;

    // Number of zero pad bits below a right-justified word of the given code.
    function automatic logic [4:0] rj_pad(input fmt_e f);
        case (f)
            FMT_RJ20: rj_pad = 5'd4;
            FMT_RJ18: rj_pad = 5'd6;
            FMT_RJ16: rj_pad = 5'd8;
            default:  rj_pad = 5'd0;
        endcase
    endfunction

    function automatic logic is_rj(input fmt_e f);
        is_rj = (f == FMT_RJ24) || (f == FMT_RJ20) || (f == FMT_RJ18) || (f == FMT_RJ16);
    endfunction

endpackage

// File: rtl/sai_rx_sync.sv
// Module: sai_rx_sync
// Brings bit clock, frame clock and data pins into the system clock domain
// through a common flop chain, and strobes once per rising bit-clock edge.
// Assumes: the bit clock high and low phases each last at least two system clocks,
// and data/frame are steady around the rising edge, so equal delays keep them aligned.
module sai_rx_sync #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             frame_i,
    input  logic [LANES-1:0] data_i,
    output logic             bit_stb_o,
    output logic             frame_o,
    output logic [LANES-1:0] data_o
);
    localparam int VW = LANES + 2;

    logic [VW-1:0] pipe_q [STAGES];
    logic          bclk_d_q;

    // Shift all serial inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            pipe_q[0] <= {bclk_i, frame_i, data_i};
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            bclk_d_q <= pipe_q[STAGES-1][VW-1];
        end
    end

    // Rising edge of the synchronized bit clock, with the aligned frame and data bits.
    always_comb begin
        bit_stb_o = pipe_q[STAGES-1][VW-1] & ~bclk_d_q;
        frame_o   = pipe_q[STAGES-1][VW-2];
        data_o    = pipe_q[STAGES-1][LANES-1:0];
    end

endmodule

// File: rtl/sai_rx_framer.sv
// Module: sai_rx_framer
// Tracks the frame clock and the bit position since the last frame boundary.
// Stereo framing: any level change is a boundary. TDM framing: only a rising level is.
// Assumes: the frame clock is sampled only on bit strobes; the position saturates.
module sai_rx_framer #(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             frame_i,
    input  logic             tdm_i,
    output logic             edge_o,
    output logic [POS_W-1:0] pos_o,
    output logic             frame_prev_o,
    output logic             synced_o,
    output logic             was_synced_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             has_frame_q;
    logic             frame_q;
    logic [POS_W-1:0] pos_q;
    logic             synced_q;

    // Boundary detection and position of the bit being taken now.
    always_comb begin
        if (tdm_i) edge_o = stb_i && has_frame_q && frame_i && !frame_q;
        else       edge_o = stb_i && has_frame_q && (frame_i != frame_q);
        if (edge_o)                pos_o = '0;
        else if (pos_q == POS_MAX) pos_o = POS_MAX;
        else                       pos_o = pos_q + 1'b1;
        synced_o     = synced_q | edge_o;
        was_synced_o = synced_q;
        frame_prev_o = frame_q;
    end

    // Register frame level, position and lock state on every bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_frame_q <= 1'b0;
            frame_q     <= 1'b0;
            pos_q       <= POS_MAX;
            synced_q    <= 1'b0;
        end else if (stb_i) begin
            has_frame_q <= 1'b1;
            frame_q     <= frame_i;
            pos_q       <= pos_o;
            synced_q    <= synced_o;
        end
    end

endmodule

// File: rtl/sai_rx_lane.sv
// Module: sai_rx_lane
// One data pin: shifts bits in MSB first, decides when a word is complete for
// the selected framing, and emits a sign-extended sample with its channel number.
// Assumes: fmt is held steady outside reset; framer outputs are valid with stb_i.
module sai_rx_lane
    import sai_rx_pkg::*;
#(
    parameter int LANE     = 0,
    parameter int SAMPLE_W = 24,
    parameter int CORE_W   = 28,
    parameter int SLOT_W   = 32,
    parameter int TDM_CH   = 16,
    parameter int CH_W     = 4,
    parameter int POS_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt_i,
    input  logic              stb_i,
    input  logic              d_i,
    input  logic              edge_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              frame_i,
    input  logic              frame_prev_i,
    input  logic              synced_i,
    input  logic              was_synced_i,
    output logic              vld_o,
    output logic [CH_W-1:0]   chan_o,
    output logic [CORE_W-1:0] data_o
);
    localparam int  SLOT_LOG  = $clog2(SLOT_W);
    localparam int  SLOT_IW   = POS_W - SLOT_LOG;
    localparam int  EXT_W     = CORE_W - SAMPLE_W;
    localparam bit  IN_TDM8   = (LANE == PIN_TDM_LO) || (LANE == PIN_TDM_HI);
    localparam bit  IN_TDM16  = (LANE == PIN_TDM_HI);
    localparam int  TDM8_BASE = (LANE == PIN_TDM_HI) ? TDM_CH / 2 : 0;

    logic [SAMPLE_W-1:0] sh_q, sh_nxt, rj_word, word;
    logic [SLOT_IW-1:0]  slot;
    logic [SLOT_LOG-1:0] slot_bit;
    logic                fire;
    logic [CH_W-1:0]     chan;
    logic                vld_q;
    logic [CH_W-1:0]     chan_q;
    logic [CORE_W-1:0]   data_q;

    // Word completion and channel selection for the chosen framing.
    always_comb begin
        sh_nxt   = {sh_q[SAMPLE_W-2:0], d_i};
        rj_word  = sh_q << rj_pad(fmt_i);
        slot     = pos_i[POS_W-1:SLOT_LOG];
        slot_bit = pos_i[SLOT_LOG-1:0];
        fire     = 1'b0;
        word     = sh_nxt;
        chan     = CH_W'(2 * LANE) | CH_W'(frame_i);
        case (fmt_i)
            FMT_I2S: fire = synced_i && (pos_i == POS_W'(SAMPLE_W));
            FMT_LJ:  fire = synced_i && (pos_i == POS_W'(SAMPLE_W - 1));
            FMT_TDM8: begin
                fire = IN_TDM8 && synced_i && (slot_bit == SLOT_LOG'(SAMPLE_W - 1))
                       && (slot < SLOT_IW'(TDM_CH / 2));
                chan = CH_W'(TDM8_BASE) + CH_W'(slot);
            end
            FMT_TDM16: begin
                fire = IN_TDM16 && synced_i && (slot_bit == SLOT_LOG'(SAMPLE_W - 1));
                chan = CH_W'(slot);
            end
            default: begin
                fire = edge_i && was_synced_i;
                word = rj_word;
                chan = CH_W'(2 * LANE) | CH_W'(frame_prev_i);
            end
        endcase
    end

    // Shift register of received bits, advanced on every bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (stb_i) sh_q <= sh_nxt;
    end

    // Output register: one-cycle strobe with channel and sign-extended word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            chan_q <= '0;
            data_q <= '0;
        end else begin
            vld_q <= stb_i && fire;
            if (stb_i && fire) begin
                chan_q <= chan;
                data_q <= {{EXT_W{word[SAMPLE_W-1]}}, word};
            end
        end
    end

    assign vld_o  = vld_q;
    assign chan_o = chan_q;
    assign data_o = data_q;

    // R1: a sample only ever follows a sampled rising bit-clock edge.
    assert_after_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(stb_i));

    // R5: right-justified words come out only at a frame-clock transition.
    assert_rj_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && is_rj($past(fmt_i))) |-> $past(edge_i));

    // R6: in two-channel framings, a pin only reports its own channel pair.
    assert_pair_of_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && ($past(fmt_i) != FMT_TDM8) && ($past(fmt_i) != FMT_TDM16))
        |-> (chan_q[CH_W-1:1] == (CH_W-1)'(LANE)));

    // R7: in two-wire TDM, each pin reports only its own bank of eight.
    assert_tdm8_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && ($past(fmt_i) == FMT_TDM8)) |-> (chan_q[CH_W-1] == (TDM8_BASE != 0)));

    // R8: pins without a TDM stream stay silent in TDM framings.
    assert_tdm_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(fmt_i) == FMT_TDM8) && !IN_TDM8) || (($past(fmt_i) == FMT_TDM16) && !IN_TDM16))
        |-> !vld_q);

endmodule

// File: rtl/sai_rx_top.sv
// Module: sai_rx_top
// Slave serial audio receiver: four data pins, external bit and frame clocks,
// eight framings chosen by fmt_sel, one output lane per pin.
// Assumes: fmt_sel changes only under reset; bit clock well below clk/4.
module sai_rx_top
    import sai_rx_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int SMP_W   = SAMPLE_W,
    parameter int WORD_W  = CORE_W,
    parameter int SYNC_N  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_clk,
    input  logic                     frame_clk,
    input  logic [N_LANES-1:0]       sdin,
    input  logic [2:0]               fmt_sel,
    output logic [N_LANES-1:0]       smp_valid,
    output logic [N_LANES*CH_W-1:0]  smp_chan,
    output logic [N_LANES*WORD_W-1:0] smp_data
);
    fmt_e               fmt;
    logic               tdm;
    logic               stb, frame_s, edge_s, frame_prev, synced, was_synced;
    logic [N_LANES-1:0] data_s;
    logic [POS_W-1:0]   pos;

    // Decode the framing code.
    always_comb begin
        fmt = fmt_e'(fmt_sel);
        tdm = (fmt == FMT_TDM8) || (fmt == FMT_TDM16);
    end

    sai_rx_sync #(
        .LANES (N_LANES),
        .STAGES(SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bit_clk),
        .frame_i  (frame_clk),
        .data_i   (sdin),
        .bit_stb_o(stb),
        .frame_o  (frame_s),
        .data_o   (data_s)
    );

    sai_rx_framer #(
        .POS_W(POS_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (stb),
        .frame_i     (frame_s),
        .tdm_i       (tdm),
        .edge_o      (edge_s),
        .pos_o       (pos),
        .frame_prev_o(frame_prev),
        .synced_o    (synced),
        .was_synced_o(was_synced)
    );

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        sai_rx_lane #(
            .LANE    (k),
            .SAMPLE_W(SMP_W),
            .CORE_W  (WORD_W),
            .SLOT_W  (SLOT_W),
            .TDM_CH  (TDM_CH),
            .CH_W    (CH_W),
            .POS_W   (POS_W)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .fmt_i       (fmt),
            .stb_i       (stb),
            .d_i         (data_s[k]),
            .edge_i      (edge_s),
            .pos_i       (pos),
            .frame_i     (frame_s),
            .frame_prev_i(frame_prev),
            .synced_i    (synced),
            .was_synced_i(was_synced),
            .vld_o       (smp_valid[k]),
            .chan_o      (smp_chan[k*CH_W +: CH_W]),
            .data_o      (smp_data[k*WORD_W +: WORD_W])
        );
    end

    // R11: nothing is reported before the first frame boundary is seen.
    assert_no_early_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(synced)) |-> (smp_valid == '0));

endmodule

// File: tb/sai_rx_top_test.sv
module sai_rx_top_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         lrck = 1'b0;
    logic [3:0]   sdin = 4'h0;
    logic [2:0]   fmt = 3'd0;
    logic [3:0]   smp_valid;
    logic [15:0]  smp_chan;
    logic [111:0] smp_data;

    int    checks = 0;
    int    errors = 0;
    int    seen = 0;
    bit    finished = 1'b0;
    string cur_req = "R11";
    logic [33:0] expq[$];

    always #2.5 clk = ~clk;

    sai_rx_top uut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bclk), .frame_clk(lrck),
        .sdin(sdin), .fmt_sel(fmt), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data)
    );

    function automatic logic [27:0] sext(input logic [23:0] w);
        return {{4{w[23]}}, w};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model-side comparison: every strobe must match the next expected sample.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int k = 0; k < 4; k++) begin
                if (smp_valid[k]) begin
                    logic [33:0] got;
                    seen++;
                    got = {2'(k), smp_chan[k*4 +: 4], smp_data[k*28 +: 28]};
                    if (expq.size() == 0) begin
                        chk(1'b0, cur_req, "unexpected sample", 64'(got), 64'h0);
                    end else begin
                        logic [33:0] e;
                        e = expq.pop_front();
                        chk(got == e, cur_req, "lane/chan/data", 64'(got), 64'(e));
                    end
                end
            end
        end
    end

    task automatic drive_bit(input logic lr, input logic [3:0] d, input bit glitch);
        sdin = d;
        lrck = lr;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        if (glitch) sdin = ~d;
        repeat (2) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic do_reset(input logic [2:0] code);
        rst_n = 1'b0;
        fmt = code;
        bclk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_valid == 4'h0, "R11", "valid after reset", 64'(smp_valid), 64'h0);
        seen = 0;
    endtask

    function automatic int word_len(input logic [2:0] code);
        case (code)
            3'd3: return 20;
            3'd4: return 18;
            3'd5: return 16;
            default: return 24;
        endcase
    endfunction

    // Serial bit i of a 32-bit half-frame for word w under the given code.
    function automatic logic stereo_bit(input logic [2:0] code, input logic [23:0] w, input int i);
        int wl;
        wl = word_len(code);
        if (code == 3'd0) return (i >= 1 && i <= 24) ? w[24 - i] : 1'b1;
        if (code == 3'd1) return (i < 24) ? w[23 - i] : 1'b1;
        return (i >= 32 - wl) ? w[23 - (i - (32 - wl))] : 1'b1;
    endfunction

    task automatic run_stereo(input logic [2:0] code, input int nframes, input bit glitch, input string req);
        logic [23:0] w [4];
        logic [23:0] mask;
        int wl;
        do_reset(code);
        cur_req = "R11";
        for (int i = 0; i < 6; i++) drive_bit(1'b1, 4'($urandom), 1'b0);
        repeat (8) @(negedge clk);
        chk(seen == 0, "R11", "samples before first frame edge", 64'(seen), 64'h0);
        cur_req = req;
        wl = word_len(code);
        mask = 24'hFFFFFF << (24 - wl);
        for (int f = 0; f < nframes; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < 4; k++) w[k] = 24'($urandom);
                if (f == 0 && h == 0) begin
                    w[0] = 24'h800000;
                    w[1] = 24'h7FFFFF;
                end
                for (int k = 0; k < 4; k++)
                    expq.push_back({2'(k), 4'(2 * k + h), sext(w[k] & mask)});
                for (int i = 0; i < 32; i++) begin
                    logic [3:0] d;
                    for (int k = 0; k < 4; k++) d[k] = stereo_bit(code, w[k], i);
                    drive_bit(1'(h), d, glitch);
                end
            end
        end
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 4'hF, 1'b0);
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, req, "samples missing", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    task automatic run_tdm(input logic [2:0] code, input int nframes, input string req);
        logic [23:0] lo [16];
        logic [23:0] hi [16];
        int nslot;
        do_reset(code);
        cur_req = "R11";
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 4'($urandom), 1'b0);
        repeat (8) @(negedge clk);
        chk(seen == 0, "R11", "samples before frame sync", 64'(seen), 64'h0);
        cur_req = req;
        nslot = (code == 3'd6) ? 8 : 16;
        for (int f = 0; f < nframes; f++) begin
            for (int s = 0; s < 16; s++) begin
                lo[s] = 24'($urandom);
                hi[s] = 24'($urandom);
            end
            hi[0] = 24'h800000;
            lo[0] = 24'hFFFFFF;
            for (int s = 0; s < nslot; s++) begin
                if (code == 3'd6) begin
                    expq.push_back({2'd2, 4'(8 + s), sext(hi[s])});
                    expq.push_back({2'd3, 4'(s), sext(lo[s])});
                end else begin
                    expq.push_back({2'd2, 4'(s), sext(hi[s])});
                end
            end
            for (int i = 0; i < nslot * 32; i++) begin
                logic [3:0] d;
                int s;
                int b;
                s = i / 32;
                b = i % 32;
                d = 4'($urandom);
                if (b < 24) begin
                    d[2] = hi[s][23 - b];
                    if (code == 3'd6) d[3] = lo[s][23 - b];
                end
                drive_bit((i < 32) ? 1'b1 : 1'b0, d, 1'b0);
            end
        end
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 4'($urandom), 1'b0);
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, req, "slots missing", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    initial begin
        run_stereo(3'd0, 3, 1'b0, "R3 R2 R6 R10");
        run_stereo(3'd1, 3, 1'b1, "R4 R1 R2 R6 R10");
        run_stereo(3'd2, 2, 1'b0, "R5 R2 R6 R10");
        run_stereo(3'd3, 2, 1'b0, "R5 R2 R6");
        run_stereo(3'd4, 2, 1'b0, "R5 R2 R6");
        run_stereo(3'd5, 2, 1'b0, "R5 R2 R6 R10");
        run_tdm(3'd6, 2, "R7 R9 R8 R2 R10");
        run_tdm(3'd7, 2, "R8 R9 R2 R10");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule